// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This controller steps a chip through five power modes: running, a light sleep where only the processor clock stops, a reduced-voltage sleep, a deep sleep with everything outside the always-on domain unpowered, and a full shutdown. Software asks for a mode through a sleep request and a 3-bit target code. The request is honoured only while the processor reports itself idle. The controller then drives the clock enables, the supply-lowering request, the enable for the switchable power domain, the 32 kHz source select and a system reset request, in a fixed order on the way down and the reverse order on the way up.

Each sleep mode accepts its own set of wake sources and leaves in its own way. Light sleep resumes at once. Reduced-voltage sleep restores the supplies, waits for the regulator's ready flag and a settle time before it resumes. Deep sleep restores power, waits for power-good and the settle time, then issues a reset instead of resuming. Shutdown has no way out except the power-on reset input. The settle time is a programmable count of 32 kHz ticks. The ticks arrive as a one-cycle enable pulse in the system clock domain.

Top module: `pwrseq_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, both clock enables and `dom_on` are 1, and `lowv_req`, `lf_ring_sel` and `sys_rst_req` are 0.
- R2: A sleep request is taken only when `sleep_req` and `cpu_idle` are both high and `sleep_mode` is 1 (light), 2 (reduced voltage), 3 (deep) or 4 (shutdown). Any other code, or a request without idle, leaves every output unchanged.
- R3: A light-sleep request clears `cpu_clk_en` one cycle later and leaves `periph_clk_en` high. Any bit of `periph_irq`, or `gpio_wake`, or `rtc_wake` sets `cpu_clk_en` again one cycle later.
- R4: For reduced-voltage, deep and shutdown requests, both clock enables fall one cycle after the request. One cycle after that, `lowv_req` rises or `dom_on` falls.
- R5: In reduced-voltage sleep only `gpio_wake` or `rtc_wake` ends the mode. `periph_irq` has no effect on any output.
- R6: After a reduced-voltage wake, `lowv_req` drops one cycle later. The clocks stay gated until `volt_ready` has been seen high and the settle time has passed.
- R7: The settle phase starts in the cycle after the ready or power-good input is sampled high. It lasts until `settle_ticks` pulses of `lf_tick` have been counted. The clocks come back one cycle after the count reaches `settle_ticks`, so a value of 0 means a single cycle.
- R8: In deep sleep `dom_on` is 0 and `lf_ring_sel` is 1. Only `gpio_wake` or `rtc_wake` raises `dom_on` again. `lf_ring_sel` stays 1 from power-down through the reset request cycle.
- R9: On leaving deep sleep, after power-good and the settle time, `sys_rst_req` is high for exactly one cycle with the clocks still gated. Both clock enables rise in the next cycle.
- R10: In shutdown the clocks are gated and `dom_on` is 0. No input other than `rst` changes any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| sleep_req | input | 1 | Request to enter the mode in `sleep_mode` |
| sleep_mode | input | 3 | Target code: 1 light, 2 reduced voltage, 3 deep, 4 shutdown |
| cpu_idle | input | 1 | Processor has no work pending |
| periph_irq | input | N_IRQ | Peripheral interrupt lines |
| gpio_wake | input | 1 | Pin wake event |
| rtc_wake | input | 1 | Always-on counter timeout wake |
| lf_tick | input | 1 | One-cycle pulse per 32 kHz period |
| settle_ticks | input | SETTLE_W | Settle length in 32 kHz ticks |
| volt_ready | input | 1 | Supplies are back at normal voltage |
| pwr_good | input | 1 | Switchable domain power is stable |
| cpu_clk_en | output | 1 | Processor clock enable |
| periph_clk_en | output | 1 | Digital peripheral clock enable |
| lowv_req | output | 1 | Request to lower always-on and core supplies |
| dom_on | output | 1 | Power enable for the switchable domain |
| lf_ring_sel | output | 1 | 32 kHz source: 1 ring oscillator, 0 crystal-derived |
| sys_rst_req | output | 1 | System reset request |

## Verification
A wrong mode state shows at the ports at once. Every output is a pure decode of the state register, so a bad transition changes the clock enables, the supply request or the domain enable in the cycle after the edge that caused it. A wrong settle count shows only when that phase ends: the clock enables rise a cycle early or late against the tick count. A lost target code shows one cycle after gating, as the wrong choice between a raised `lowv_req` and a fallen `dom_on`. For a deep-sleep exit it also shows as a missing `sys_rst_req` pulse.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_NAP  = 3'd1,
        TGT_LOWV = 3'd2,
        TGT_DEEP = 3'd3,
        TGT_OFF  = 3'd4
    } tgt_t;

    typedef enum logic [3:0] {
        ST_RUN,
        ST_NAP,
        ST_GATE,
        ST_LV_LOW,
        ST_LV_UP,
        ST_DP_OFF,
        ST_DP_UP,
        ST_SETTLE,
        ST_RESET,
        ST_SHUT
    } st_t;

    typedef struct packed {
        logic cpu_clk;
        logic per_clk;
        logic lowv;
        logic dom_on;
        logic lf_ring;
        logic rst_req;
    } ctl_t;

    function automatic logic tgt_ok(input logic [2:0] code);
        return (code >= 3'd1) && (code <= 3'd4);
    endfunction

    function automatic st_t down_state(input tgt_t t);
        case (t)
            TGT_LOWV: return ST_LV_LOW;
            TGT_DEEP: return ST_DP_OFF;
            default:  return ST_SHUT;
        endcase
    endfunction

endpackage

// File: rtl/pwrseq_wake.sv
module pwrseq_wake
    import pwrseq_pkg::*;
#(
    parameter int N_IRQ = 8
) (
    input  st_t              st,
    input  logic [N_IRQ-1:0] irq,
    input  logic             gpio,
    input  logic             rtc,
    output logic             wake
);
    logic aon_hit;
    logic any_irq;

    assign aon_hit = gpio | rtc;
    assign any_irq = |irq;

    always_comb begin
        case (st)
            ST_NAP:               wake = any_irq | aon_hit;
            ST_LV_LOW, ST_DP_OFF: wake = aon_hit;
            default:              wake = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwrseq_settle.sv
module pwrseq_settle #(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic                tick,
    input  logic [SETTLE_W-1:0] limit,
    output logic                done
);
    logic [SETTLE_W-1:0] cnt;

    assign done = run && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick && !done) begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_settle_bound_R7: assert property (@(posedge clk) disable iff (rst)
        (run && $stable(limit)) |-> (cnt <= limit));
endmodule

// File: rtl/pwrseq_outdec.sv
module pwrseq_outdec
    import pwrseq_pkg::*;
(
    input  st_t  st,
    input  tgt_t tgt,
    output ctl_t ctl
);
    always_comb begin
        ctl         = '0;
        ctl.dom_on  = 1'b1;
        case (st)
            ST_RUN: begin
                ctl.cpu_clk = 1'b1;
                ctl.per_clk = 1'b1;
            end
            ST_NAP:    ctl.per_clk = 1'b1;
            ST_LV_LOW: ctl.lowv    = 1'b1;
            ST_DP_OFF: begin
                ctl.dom_on  = 1'b0;
                ctl.lf_ring = 1'b1;
            end
            ST_DP_UP:   ctl.lf_ring = 1'b1;
            ST_SETTLE:  ctl.lf_ring = (tgt == TGT_DEEP);
            ST_RESET: begin
                ctl.lf_ring = 1'b1;
                ctl.rst_req = 1'b1;
            end
            ST_SHUT:    ctl.dom_on = 1'b0;
            default:    ;
        endcase
    end
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
    import pwrseq_pkg::*;
#(
    parameter int N_IRQ    = 8,
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sleep_req,
    input  logic [2:0]          sleep_mode,
    input  logic                cpu_idle,
    input  logic [N_IRQ-1:0]    periph_irq,
    input  logic                gpio_wake,
    input  logic                rtc_wake,
    input  logic                lf_tick,
    input  logic [SETTLE_W-1:0] settle_ticks,
    input  logic                volt_ready,
    input  logic                pwr_good,
    output logic                cpu_clk_en,
    output logic                periph_clk_en,
    output logic                lowv_req,
    output logic                dom_on,
    output logic                lf_ring_sel,
    output logic                sys_rst_req
);
    st_t  st_q, st_d;
    tgt_t tgt_q, tgt_d;
    logic wake;
    logic settle_done;
    logic accept;
    ctl_t ctl;

    assign accept = sleep_req && cpu_idle && tgt_ok(sleep_mode);

    pwrseq_wake #(.N_IRQ(N_IRQ)) u_wake (
        .st   (st_q),
        .irq  (periph_irq),
        .gpio (gpio_wake),
        .rtc  (rtc_wake),
        .wake (wake)
    );

    pwrseq_settle #(.SETTLE_W(SETTLE_W)) u_settle (
        .clk   (clk),
        .rst   (rst),
        .run   (st_q == ST_SETTLE),
        .tick  (lf_tick),
        .limit (settle_ticks),
        .done  (settle_done)
    );

    pwrseq_outdec u_dec (
        .st  (st_q),
        .tgt (tgt_q),
        .ctl (ctl)
    );

    always_comb begin
        st_d  = st_q;
        tgt_d = tgt_q;
        case (st_q)
            ST_RUN: if (accept) begin
                tgt_d = tgt_t'(sleep_mode);
                st_d  = (tgt_t'(sleep_mode) == TGT_NAP) ? ST_NAP : ST_GATE;
            end
            ST_NAP:    if (wake) st_d = ST_RUN;
            ST_GATE:   st_d = down_state(tgt_q);
            ST_LV_LOW: if (wake) st_d = ST_LV_UP;
            ST_LV_UP:  if (volt_ready) st_d = ST_SETTLE;
            ST_DP_OFF: if (wake) st_d = ST_DP_UP;
            ST_DP_UP:  if (pwr_good) st_d = ST_SETTLE;
            ST_SETTLE: if (settle_done) st_d = (tgt_q == TGT_DEEP) ? ST_RESET : ST_RUN;
            ST_RESET:  st_d = ST_RUN;
            ST_SHUT:   st_d = ST_SHUT;
            default:   st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_RUN;
            tgt_q <= TGT_NONE;
        end else begin
            st_q  <= st_d;
            tgt_q <= tgt_d;
        end
    end

    assign cpu_clk_en    = ctl.cpu_clk;
    assign periph_clk_en = ctl.per_clk;
    assign lowv_req      = ctl.lowv;
    assign dom_on        = ctl.dom_on;
    assign lf_ring_sel   = ctl.lf_ring;
    assign sys_rst_req   = ctl.rst_req;

    assert_busy_stays_R2: assert property (@(posedge clk) disable iff (rst)
        (cpu_clk_en && !cpu_idle) |=> cpu_clk_en);

    assert_gate_first_R4: assert property (@(posedge clk) disable iff (rst)
        (lowv_req || !dom_on) |-> (!cpu_clk_en && !periph_clk_en));

    assert_lowv_after_gate_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(lowv_req) |-> $past(!periph_clk_en));

    assert_lv_ignores_irq_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_LV_LOW && !gpio_wake && !rtc_wake) |=> lowv_req);

    assert_wait_ready_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_LV_UP && !volt_ready) |=> !periph_clk_en);

    assert_ring_in_deep_R8: assert property (@(posedge clk) disable iff (rst)
        (!dom_on && !cpu_clk_en && st_q != ST_SHUT) |-> lf_ring_sel);

    assert_rst_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |=> (!sys_rst_req && cpu_clk_en && periph_clk_en));

    assert_shut_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SHUT) |=> (st_q == ST_SHUT && !dom_on));
endmodule

// File: tb/sim_pwrseq_ctrl.sv
module sim_pwrseq_ctrl;
    localparam int NI = 8;
    localparam int SW = 8;

    localparam int M_RUN = 0, M_NAP = 1, M_GATE = 2, M_LVLOW = 3, M_LVUP = 4,
                   M_DPOFF = 5, M_DPUP = 6, M_SETTLE = 7, M_RESET = 8, M_SHUT = 9;

    logic clk = 0;
    logic rst = 1;
    logic sleep_req = 0;
    logic [2:0] sleep_mode = 0;
    logic cpu_idle = 0;
    logic [NI-1:0] periph_irq = 0;
    logic gpio_wake = 0, rtc_wake = 0, lf_tick = 0;
    logic [SW-1:0] settle_ticks = 0;
    logic volt_ready = 1, pwr_good = 1;
    logic cpu_clk_en, periph_clk_en, lowv_req, dom_on, lf_ring_sel, sys_rst_req;

    int compared = 0, mismatched = 0;
    int mst = M_RUN, mtgt = 0, mcnt = 0;
    bit started = 0, done = 0;
    int tick_div = 0;

    always #4 clk = ~clk;

    pwrseq_ctrl #(.N_IRQ(NI), .SETTLE_W(SW)) u0 (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .sleep_mode(sleep_mode),
        .cpu_idle(cpu_idle), .periph_irq(periph_irq), .gpio_wake(gpio_wake),
        .rtc_wake(rtc_wake), .lf_tick(lf_tick), .settle_ticks(settle_ticks),
        .volt_ready(volt_ready), .pwr_good(pwr_good), .cpu_clk_en(cpu_clk_en),
        .periph_clk_en(periph_clk_en), .lowv_req(lowv_req), .dom_on(dom_on),
        .lf_ring_sel(lf_ring_sel), .sys_rst_req(sys_rst_req)
    );

    // reference model, stepped on each rising edge
    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            mst = M_RUN; mtgt = 0; mcnt = 0;
        end else begin
            case (mst)
                M_RUN: if (sleep_req && cpu_idle && sleep_mode >= 1 && sleep_mode <= 4) begin
                    mtgt = int'(sleep_mode);
                    mst = (mtgt == 1) ? M_NAP : M_GATE;
                end
                M_NAP:   if (periph_irq != 0 || gpio_wake || rtc_wake) mst = M_RUN;
                M_GATE:  mst = (mtgt == 2) ? M_LVLOW : (mtgt == 3) ? M_DPOFF : M_SHUT;
                M_LVLOW: if (gpio_wake || rtc_wake) mst = M_LVUP;
                M_LVUP:  if (volt_ready) begin mst = M_SETTLE; mcnt = 0; end
                M_DPOFF: if (gpio_wake || rtc_wake) mst = M_DPUP;
                M_DPUP:  if (pwr_good) begin mst = M_SETTLE; mcnt = 0; end
                M_SETTLE: begin
                    if (mcnt == int'(settle_ticks)) mst = (mtgt == 3) ? M_RESET : M_RUN;
                    else if (lf_tick) mcnt++;
                end
                M_RESET: mst = M_RUN;
                default: ;
            endcase
        end
    end

    function automatic logic [5:0] expect_out(int s, int t);
        logic c, p, l, d, r, q;
        c = (s == M_RUN);
        p = (s == M_RUN) || (s == M_NAP);
        l = (s == M_LVLOW);
        d = !((s == M_DPOFF) || (s == M_SHUT));
        r = (s == M_DPOFF) || (s == M_DPUP) || (s == M_RESET) || (s == M_SETTLE && t == 3);
        q = (s == M_RESET);
        return {c, p, l, d, r, q};
    endfunction

    function automatic string tag_of(int s);
        case (s)
            M_RUN:    return "R2";
            M_NAP:    return "R3";
            M_GATE:   return "R4";
            M_LVLOW:  return "R5";
            M_LVUP:   return "R6";
            M_SETTLE: return "R7";
            M_DPOFF, M_DPUP: return "R8";
            M_RESET:  return "R9";
            default:  return "R10";
        endcase
    endfunction

    // comparison every cycle, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            logic [5:0] act, exp_v;
            act   = {cpu_clk_en, periph_clk_en, lowv_req, dom_on, lf_ring_sel, sys_rst_req};
            exp_v = expect_out(mst, mtgt);
            compared++;
            if (act !== exp_v) begin
                mismatched++;
                $display("FAIL %s t=%0t outputs actual=%b expected=%b",
                         rst ? "R1" : tag_of(mst), $time, act, exp_v);
            end
        end
    end

    // 32 kHz tick stand-in: one pulse every 4 system cycles
    initial begin
        forever begin
            @(posedge clk); #2;
            tick_div = (tick_div + 1) % 4;
            lf_tick = (tick_div == 0);
        end
    end

    task automatic cyc(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic ask(input logic [2:0] m, input logic idle);
        sleep_req = 1; sleep_mode = m; cpu_idle = idle;
        cyc(1);
        sleep_req = 0;
    endtask

    task automatic pulse_gpio();
        gpio_wake = 1; cyc(1); gpio_wake = 0;
    endtask

    task automatic pulse_rtc();
        rtc_wake = 1; cyc(1); rtc_wake = 0;
    endtask

    initial begin
        cyc(3);
        rst = 0;                        // R1: reset state compared above
        cyc(2);

        // R2: busy CPU and bad codes leave the block running
        ask(3'd2, 1'b0); cyc(2);
        ask(3'd0, 1'b1); cyc(2);
        ask(3'd5, 1'b1); cyc(2);
        ask(3'd7, 1'b1); cyc(2);

        // R3: light sleep, woken by an interrupt, then by a pin
        ask(3'd1, 1'b1); cyc(4);
        periph_irq = 8'h20; cyc(1); periph_irq = 0; cyc(2);
        ask(3'd1, 1'b1); cyc(3);
        pulse_gpio(); cyc(2);

        // R4 R5 R6 R7: reduced-voltage sleep, irq ignored, late ready, settle 3
        settle_ticks = 3;
        ask(3'd2, 1'b1);
        volt_ready = 0; cyc(4);
        periph_irq = 8'hFF; cyc(3); periph_irq = 0; cyc(2);
        pulse_gpio(); cyc(5);
        volt_ready = 1; cyc(20);

        // R7: settle of zero, rtc wake
        settle_ticks = 0;
        ask(3'd2, 1'b1); cyc(3);
        pulse_rtc(); cyc(6);

        // R8 R9: deep sleep, irq ignored, late power-good, settle 2, reset pulse
        settle_ticks = 2;
        ask(3'd3, 1'b1);
        pwr_good = 0; cyc(4);
        periph_irq = 8'h01; cyc(2); periph_irq = 0;
        pulse_rtc(); cyc(4);
        pwr_good = 1; cyc(16);

        // R10: shutdown ignores everything, then power-on reset
        ask(3'd4, 1'b1); cyc(3);
        gpio_wake = 1; rtc_wake = 1; periph_irq = '1; cyc(3);
        gpio_wake = 0; rtc_wake = 0; periph_irq = 0;
        ask(3'd1, 1'b1); cyc(3);
        rst = 1; cyc(2); rst = 0;       // R1: back to running
        cyc(4);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            mismatched++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule